// File: doc/BRIEF.md
# Load Queue with Store Ordering Check

This block tracks in-flight loads of an out-of-order core in a circular queue. Loads get a slot in program order at dispatch. Each slot holds the load's sequence number and the store-queue tail index seen at that moment. The load's effective address is written into its slot once the load executes. A store that is dispatched samples the current load-queue tail, so it knows which loads come after it in program order.

When a store resolves its address, the block compares it in one cycle against every executed load from the store's sampled index up to the current tail. Addresses are compared at block granularity. The oldest matching load is captured as the violator, and it is held until the consumer reads it. Commit retires a run of loads from the head in one cycle. A squash trims a run of younger loads from the tail in one cycle. The block also reports how many new memory operations dispatch may send, taking the load queue and an external store-queue occupancy into account.

Top module: `ldq_order_guard`

## Requirements
- R1: After reset the queue is empty. `ld_ready_o` is 1, `lq_tail_o` is 0, `viol_o` is 0 and `free_slots_o` equals min(LQ_DEPTH, SQ_DEPTH - `sq_used_i`).
- R2: The queue holds at most LQ_DEPTH loads in LQ_DEPTH+1 slots. `ld_ready_o` is 0 exactly when the slot after the tail is the head. An allocation offered while it is 0 changes nothing.
- R3: An accepted allocation places the load in slot `lq_tail_o`. The tail then advances by one modulo LQ_DEPTH+1. The load keeps `ld_sq_tail_i`, which is later reported as `viol_sq_idx_o`.
- R4: A newly allocated load cannot match any store until its address is written. `exec_valid_i` writes `exec_addr_i` into slot `exec_idx_i` only when that slot holds a load. A write to a free slot is dropped.
- R5: A store check compares only the slots from `st_chk_lq_idx_i` up to, but not including, the current tail, wrapping past the last slot. If the start equals the tail, no slot is compared.
- R6: A load matches when its address and the store address agree on bits ADDR_W-1 down to BLK_LSB. The violator is the first match in program order from the start index. `viol_o` and the violator fields update one cycle after the check.
- R7: While a violator is pending it is held, and further store checks are skipped. Asserting `viol_read_i` clears `viol_o` in the next cycle.
- R8: A commit retires, in one cycle, every load from the head onward up to the first load whose sequence number is later than `commit_seq_i`.
- R9: A squash removes, in one cycle, every load from the tail backward up to the first load whose sequence number is not later than `squash_seq_i`. In a squash cycle, allocation and commit are ignored.
- R10: `free_slots_o` is min(LQ_DEPTH - loads held, SQ_DEPTH - `sq_used_i`). The second term is floored at 0.
- R11: Sequence numbers are compared by the sign of their SEQ_W-bit difference, so ordering holds across the wrap from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_alloc_i | input | 1 | Allocate a load at the tail |
| ld_seq_i | input | SEQ_W | Sequence number of the allocated load |
| ld_sq_tail_i | input | SQI_W | Store-queue tail seen by the allocated load |
| ld_ready_o | output | 1 | A load can be accepted this cycle |
| lq_tail_o | output | IDX_W | Current tail slot (sampled by dispatched stores) |
| sq_used_i | input | CNT_W | Store-queue entries in use |
| free_slots_o | output | CNT_W | Memory operations dispatch may still send |
| exec_valid_i | input | 1 | Executed load address update |
| exec_idx_i | input | IDX_W | Slot of the executed load |
| exec_addr_i | input | ADDR_W | Effective address of the executed load |
| st_chk_valid_i | input | 1 | Store ordering check request |
| st_chk_addr_i | input | ADDR_W | Store effective address |
| st_chk_lq_idx_i | input | IDX_W | Load-queue tail sampled when the store was dispatched |
| commit_valid_i | input | 1 | Commit request |
| commit_seq_i | input | SEQ_W | Youngest committed sequence number |
| squash_valid_i | input | 1 | Squash request |
| squash_seq_i | input | SEQ_W | Loads later than this are removed |
| viol_read_i | input | 1 | Consume the pending violator |
| viol_o | output | 1 | A violator is pending |
| viol_lq_idx_o | output | IDX_W | Slot of the violating load |
| viol_seq_o | output | SEQ_W | Sequence number of the violating load |
| viol_sq_idx_o | output | SQI_W | Store-queue tail recorded by the violating load |

## Verification
The bench uses LQ_DEPTH=4, which gives five slots, and SQ_DEPTH=6 with the default 32-bit addresses, 16-bit sequence numbers and BLK_LSB=8. With five slots, a few allocations are enough to fill the queue, reach the refused allocation, and wrap the tail past the last slot. The same size lets a store window run across the wrap point. Setting the external store occupancy close to SQ_DEPTH makes the store term the smaller one in the free count. The 16-bit sequence space lets the bench allocate loads across the all-ones to zero boundary and then commit and squash there.

// File: rtl/ldq_pkg.sv
package ldq_pkg;

  function automatic int idx_add(int a, int b, int slots);
    return (a + b) % slots;
  endfunction

  // a strictly later than b in a w-bit wrapping sequence space
  function automatic logic seq_after(logic [31:0] a, logic [31:0] b, int w);
    logic [31:0] d;
    d = a - b;
    if (w < 32) d = d & ((32'd1 << w) - 32'd1);
    return (d != 32'd0) && !d[w-1];
  endfunction

endpackage

// File: rtl/ldq_window.sv
module ldq_window #(
  parameter int SLOTS = 9,
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] start_i,
  input  logic [IDX_W-1:0] stop_i,
  output logic [SLOTS-1:0] mask_o
);
  logic wrap;
  assign wrap = start_i > stop_i;

  for (genvar i = 0; i < SLOTS; i++) begin : gen_win
    localparam logic [IDX_W-1:0] SlotIdx = IDX_W'(i);
    assign mask_o[i] = wrap ? (SlotIdx >= start_i || SlotIdx < stop_i)
                            : (SlotIdx >= start_i && SlotIdx < stop_i);
  end
endmodule

// File: rtl/ldq_first_hit.sv
module ldq_first_hit
  import ldq_pkg::*;
#(
  parameter int SLOTS = 9,
  parameter int IDX_W = 4
) (
  input  logic [SLOTS-1:0] vec_i,
  input  logic [IDX_W-1:0] start_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = 0; k < SLOTS; k++) begin
      int p;
      p = idx_add(int'(start_i), k, SLOTS);
      if (!hit_o && vec_i[p]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(p);
      end
    end
  end
endmodule

// File: rtl/ldq_trim.sv
module ldq_trim
  import ldq_pkg::*;
#(
  parameter int SLOTS = 9,
  parameter int DEPTH = 8,
  parameter int IDX_W = 4,
  parameter int CNT_W = 4,
  parameter int SEQ_W = 16
) (
  input  logic [SLOTS-1:0][SEQ_W-1:0] seq_i,
  input  logic [IDX_W-1:0]            head_i,
  input  logic [IDX_W-1:0]            tail_i,
  input  logic [CNT_W-1:0]            cnt_i,
  input  logic [SEQ_W-1:0]            commit_seq_i,
  input  logic [SEQ_W-1:0]            squash_seq_i,
  output logic [CNT_W-1:0]            ret_n_o,
  output logic [SLOTS-1:0]            ret_mask_o,
  output logic [CNT_W-1:0]            sqs_n_o,
  output logic [SLOTS-1:0]            sqs_mask_o
);
  // retire run from the head
  always_comb begin
    logic run;
    run        = 1'b1;
    ret_n_o    = '0;
    ret_mask_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int p;
      p = idx_add(int'(head_i), k, SLOTS);
      if (run && (k < int'(cnt_i)) &&
          !seq_after(32'(seq_i[p]), 32'(commit_seq_i), SEQ_W)) begin
        ret_n_o       = ret_n_o + CNT_W'(1);
        ret_mask_o[p] = 1'b1;
      end else begin
        run = 1'b0;
      end
    end
  end

  // squash run from the tail
  always_comb begin
    logic run;
    run        = 1'b1;
    sqs_n_o    = '0;
    sqs_mask_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int p;
      p = idx_add(int'(tail_i), SLOTS - 1 - k, SLOTS);
      if (run && (k < int'(cnt_i)) &&
          seq_after(32'(seq_i[p]), 32'(squash_seq_i), SEQ_W)) begin
        sqs_n_o       = sqs_n_o + CNT_W'(1);
        sqs_mask_o[p] = 1'b1;
      end else begin
        run = 1'b0;
      end
    end
  end
endmodule

// File: rtl/ldq_viol_hold.sv
module ldq_viol_hold #(
  parameter int IDX_W = 4,
  parameter int SEQ_W = 16,
  parameter int SQI_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic [SQI_W-1:0] sq_i,
  input  logic             read_i,
  output logic             pend_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic [SQI_W-1:0] sq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      idx_o  <= '0;
      seq_o  <= '0;
      sq_o   <= '0;
    end else if (pend_o) begin
      if (read_i) pend_o <= 1'b0;
    end else if (cap_i) begin
      pend_o <= 1'b1;
      idx_o  <= idx_i;
      seq_o  <= seq_i;
      sq_o   <= sq_i;
    end
  end

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !read_i) |=> (pend_o && $stable(idx_o) && $stable(seq_o) && $stable(sq_o)));

  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && read_i) |=> !pend_o);

  assert_rise_from_check_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o) |-> $past(cap_i));
endmodule

// File: rtl/ldq_order_guard.sv
module ldq_order_guard
  import ldq_pkg::*;
#(
  parameter int LQ_DEPTH = 8,
  parameter int SQ_DEPTH = 8,
  parameter int ADDR_W   = 32,
  parameter int SEQ_W    = 16,
  parameter int BLK_LSB  = 8,
  localparam int SLOTS    = LQ_DEPTH + 1,
  localparam int SQ_SLOTS = SQ_DEPTH + 1,
  localparam int IDX_W    = $clog2(SLOTS),
  localparam int SQI_W    = $clog2(SQ_SLOTS),
  localparam int CNT_W    = $clog2(((SLOTS > SQ_SLOTS) ? SLOTS : SQ_SLOTS) + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_alloc_i,
  input  logic [SEQ_W-1:0]  ld_seq_i,
  input  logic [SQI_W-1:0]  ld_sq_tail_i,
  output logic              ld_ready_o,
  output logic [IDX_W-1:0]  lq_tail_o,
  input  logic [CNT_W-1:0]  sq_used_i,
  output logic [CNT_W-1:0]  free_slots_o,
  input  logic              exec_valid_i,
  input  logic [IDX_W-1:0]  exec_idx_i,
  input  logic [ADDR_W-1:0] exec_addr_i,
  input  logic              st_chk_valid_i,
  input  logic [ADDR_W-1:0] st_chk_addr_i,
  input  logic [IDX_W-1:0]  st_chk_lq_idx_i,
  input  logic              commit_valid_i,
  input  logic [SEQ_W-1:0]  commit_seq_i,
  input  logic              squash_valid_i,
  input  logic [SEQ_W-1:0]  squash_seq_i,
  input  logic              viol_read_i,
  output logic              viol_o,
  output logic [IDX_W-1:0]  viol_lq_idx_o,
  output logic [SEQ_W-1:0]  viol_seq_o,
  output logic [SQI_W-1:0]  viol_sq_idx_o
);
  localparam int BLK_W = ADDR_W - BLK_LSB;

  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  logic [SLOTS-1:0][SEQ_W-1:0] seq_bus;
  logic [SLOTS-1:0][SQI_W-1:0] sqt_bus;
  logic [SLOTS-1:0]            av_bus;
  logic [SLOTS-1:0]            occ_mask, chk_mask, hit_vec;
  logic [SLOTS-1:0]            ret_mask, sqs_mask;
  logic [CNT_W-1:0]            ret_n, sqs_n;
  logic                        alloc_fire, commit_en;
  logic                        chk_hit;
  logic [IDX_W-1:0]            chk_idx;

  // full when the slot after tail is the head
  assign ld_ready_o = IDX_W'(idx_add(int'(tail_q), 1, SLOTS)) != head_q;
  assign lq_tail_o  = tail_q;
  assign alloc_fire = ld_alloc_i && ld_ready_o && !squash_valid_i;
  assign commit_en  = commit_valid_i && !squash_valid_i;

  // free count for dispatch
  logic [CNT_W-1:0] free_lq, free_sq;
  assign free_lq = CNT_W'(LQ_DEPTH) - cnt_q;
  assign free_sq = (sq_used_i >= CNT_W'(SQ_DEPTH)) ? '0 : CNT_W'(SQ_DEPTH) - sq_used_i;
  assign free_slots_o = (free_lq < free_sq) ? free_lq : free_sq;

  ldq_window #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_occ (
    .start_i(head_q), .stop_i(tail_q), .mask_o(occ_mask)
  );

  ldq_window #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_chk_win (
    .start_i(st_chk_lq_idx_i), .stop_i(tail_q), .mask_o(chk_mask)
  );

  ldq_trim #(
    .SLOTS(SLOTS), .DEPTH(LQ_DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .SEQ_W(SEQ_W)
  ) u_trim (
    .seq_i(seq_bus), .head_i(head_q), .tail_i(tail_q), .cnt_i(cnt_q),
    .commit_seq_i(commit_seq_i), .squash_seq_i(squash_seq_i),
    .ret_n_o(ret_n), .ret_mask_o(ret_mask),
    .sqs_n_o(sqs_n), .sqs_mask_o(sqs_mask)
  );

  // per-slot storage and block-address comparators
  for (genvar i = 0; i < SLOTS; i++) begin : gen_slot
    localparam logic [IDX_W-1:0] SlotIdx = IDX_W'(i);
    logic [SEQ_W-1:0]  seq_r;
    logic [SQI_W-1:0]  sqt_r;
    logic [ADDR_W-1:0] addr_r;
    logic              av_r;
    logic              exec_hit;

    assign exec_hit = exec_valid_i && occ_mask[i] && (exec_idx_i == SlotIdx);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        seq_r  <= '0;
        sqt_r  <= '0;
        addr_r <= '0;
        av_r   <= 1'b0;
      end else begin
        if (exec_hit) begin
          addr_r <= exec_addr_i;
          av_r   <= 1'b1;
        end
        if (squash_valid_i) begin
          if (sqs_mask[i]) av_r <= 1'b0;
        end else begin
          if (commit_en && ret_mask[i]) av_r <= 1'b0;
          if (alloc_fire && (tail_q == SlotIdx)) begin
            seq_r <= ld_seq_i;
            sqt_r <= ld_sq_tail_i;
            av_r  <= 1'b0;
          end
        end
      end
    end

    assign seq_bus[i] = seq_r;
    assign sqt_bus[i] = sqt_r;
    assign av_bus[i]  = av_r;
    assign hit_vec[i] = chk_mask[i] && av_r &&
                        (addr_r[ADDR_W-1:BLK_LSB] == BLK_W'(st_chk_addr_i[ADDR_W-1:BLK_LSB]));

    assert_no_match_unexec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !av_r |-> !hit_vec[i]);
  end

  ldq_first_hit #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_first (
    .vec_i(hit_vec), .start_i(st_chk_lq_idx_i), .hit_o(chk_hit), .idx_o(chk_idx)
  );

  ldq_viol_hold #(.IDX_W(IDX_W), .SEQ_W(SEQ_W), .SQI_W(SQI_W)) u_viol (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (st_chk_valid_i && chk_hit && !viol_o),
    .idx_i   (chk_idx),
    .seq_i   (seq_bus[chk_idx]),
    .sq_i    (sqt_bus[chk_idx]),
    .read_i  (viol_read_i),
    .pend_o  (viol_o),
    .idx_o   (viol_lq_idx_o),
    .seq_o   (viol_seq_o),
    .sq_o    (viol_sq_idx_o)
  );

  // pointers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (squash_valid_i) begin
      tail_q <= IDX_W'(idx_add(int'(tail_q), SLOTS - int'(sqs_n), SLOTS));
      cnt_q  <= cnt_q - sqs_n;
    end else begin
      if (commit_en)  head_q <= IDX_W'(idx_add(int'(head_q), int'(ret_n), SLOTS));
      if (alloc_fire) tail_q <= IDX_W'(idx_add(int'(tail_q), 1, SLOTS));
      cnt_q <= cnt_q - (commit_en ? ret_n : '0) + (alloc_fire ? CNT_W'(1) : '0);
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(LQ_DEPTH));

  assert_full_refuse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_alloc_i && !ld_ready_o && !commit_valid_i && !squash_valid_i) |=>
      (cnt_q == $past(cnt_q) && tail_q == $past(tail_q)));

  assert_empty_ptrs_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |-> (head_q == tail_q));

  assert_tail_excluded_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_mask[tail_q]);

  assert_hit_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_hit |-> (hit_vec[chk_idx] && av_bus[chk_idx]));

  assert_commit_head_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_en |=> tail_q == $past(tail_q) || $past(alloc_fire));

  assert_squash_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_valid_i |=> (cnt_q <= $past(cnt_q) && head_q == $past(head_q)));
endmodule

// File: tb/sim_ldq_order_guard.sv
`timescale 1ns/1ps
module sim_ldq_order_guard;
  localparam int D   = 4;
  localparam int SQD = 6;
  localparam int S   = D + 1;
  localparam int IW  = $clog2(S);
  localparam int SW  = $clog2(SQD + 1);
  localparam int CW  = $clog2(((S > SQD + 1) ? S : SQD + 1) + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            ld_alloc = 0;
  logic [15:0]     ld_seq = 0;
  logic [SW-1:0]   ld_sqt = 0;
  logic            ld_ready;
  logic [IW-1:0]   lq_tail;
  logic [CW-1:0]   sq_used = 0;
  logic [CW-1:0]   free_slots;
  logic            ex_v = 0;
  logic [IW-1:0]   ex_idx = 0;
  logic [31:0]     ex_addr = 0;
  logic            chk_v = 0;
  logic [31:0]     chk_addr = 0;
  logic [IW-1:0]   chk_idx = 0;
  logic            cm_v = 0;
  logic [15:0]     cm_seq = 0;
  logic            sq_v = 0;
  logic [15:0]     sq_seq = 0;
  logic            rd = 0;
  logic            viol;
  logic [IW-1:0]   viol_idx;
  logic [15:0]     viol_seq;
  logic [SW-1:0]   viol_sq;

  ldq_order_guard #(.LQ_DEPTH(D), .SQ_DEPTH(SQD), .ADDR_W(32), .SEQ_W(16), .BLK_LSB(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_alloc_i(ld_alloc), .ld_seq_i(ld_seq), .ld_sq_tail_i(ld_sqt),
    .ld_ready_o(ld_ready), .lq_tail_o(lq_tail),
    .sq_used_i(sq_used), .free_slots_o(free_slots),
    .exec_valid_i(ex_v), .exec_idx_i(ex_idx), .exec_addr_i(ex_addr),
    .st_chk_valid_i(chk_v), .st_chk_addr_i(chk_addr), .st_chk_lq_idx_i(chk_idx),
    .commit_valid_i(cm_v), .commit_seq_i(cm_seq),
    .squash_valid_i(sq_v), .squash_seq_i(sq_seq),
    .viol_read_i(rd), .viol_o(viol), .viol_lq_idx_o(viol_idx),
    .viol_seq_o(viol_seq), .viol_sq_idx_o(viol_sq)
  );

  // reference model
  int m_seq[S], m_addr[S], m_sqt[S];
  bit m_av[S];
  int m_head = 0, m_tail = 0, m_cnt = 0, m_sqused = 0;
  bit m_vp = 0;
  int m_vidx = 0, m_vseq = 0, m_vsq = 0;

  typedef struct { string req; int kind; int exp; } exp_t;
  exp_t exp_q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic bit seq_gt(int a, int b);
    int d;
    d = (a - b) & 16'hFFFF;
    return d != 0 && d < 16'h8000;
  endfunction

  function automatic bit m_occ(int idx);
    for (int k = 0; k < m_cnt; k++) if ((m_head + k) % S == idx) return 1;
    return 0;
  endfunction

  function automatic void push(string req, int kind, int e);
    exp_t x;
    x.req = req; x.kind = kind; x.exp = e;
    exp_q.push_back(x);
  endfunction

  task automatic push_state(string req);
    int fl, fs;
    fl = D - m_cnt;
    fs = (m_sqused >= SQD) ? 0 : SQD - m_sqused;
    push(req, 0, (fl < fs) ? fl : fs);
    push(req, 1, (m_cnt < D) ? 1 : 0);
    push(req, 2, m_tail);
    push(req, 3, m_vp);
    if (m_vp) begin
      push(req, 4, m_vidx);
      push(req, 5, m_vseq);
      push(req, 6, m_vsq);
    end
    wait (exp_q.size() == 0);
  endtask

  // monitor
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t x;
      int act;
      string nm;
      x = exp_q.pop_front();
      case (x.kind)
        0: begin act = int'(free_slots); nm = "free_slots"; end
        1: begin act = int'(ld_ready);   nm = "ld_ready";   end
        2: begin act = int'(lq_tail);    nm = "lq_tail";    end
        3: begin act = int'(viol);       nm = "viol";       end
        4: begin act = int'(viol_idx);   nm = "viol_idx";   end
        5: begin act = int'(viol_seq);   nm = "viol_seq";   end
        default: begin act = int'(viol_sq); nm = "viol_sq"; end
      endcase
      checks++;
      if (act != x.exp) begin
        fails++;
        $display("FAIL %s %s actual=%0d expected=%0d", x.req, nm, act, x.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    ld_alloc = 0; ex_v = 0; chk_v = 0; cm_v = 0; sq_v = 0; rd = 0;
  endtask

  task automatic do_alloc(int seq, int sqt, string req);
    ld_alloc = 1; ld_seq = 16'(seq); ld_sqt = SW'(sqt);
    step();
    if (m_cnt < D) begin
      m_seq[m_tail] = seq; m_sqt[m_tail] = sqt; m_av[m_tail] = 0;
      m_tail = (m_tail + 1) % S; m_cnt++;
    end
    push_state(req);
  endtask

  task automatic do_exec(int idx, int addr, string req);
    ex_v = 1; ex_idx = IW'(idx); ex_addr = addr;
    step();
    if (m_occ(idx)) begin m_addr[idx] = addr; m_av[idx] = 1; end
    push_state(req);
  endtask

  task automatic do_check(int start, int addr, string req);
    chk_v = 1; chk_idx = IW'(start); chk_addr = addr;
    step();
    if (!m_vp) begin
      int p;
      p = start;
      for (int k = 0; k < S && p != m_tail; k++) begin
        if (m_av[p] && ((m_addr[p] >>> 8) & 24'hFFFFFF) == ((addr >>> 8) & 24'hFFFFFF)) begin
          m_vp = 1; m_vidx = p; m_vseq = m_seq[p]; m_vsq = m_sqt[p];
          break;
        end
        p = (p + 1) % S;
      end
    end
    push_state(req);
  endtask

  task automatic do_read(string req);
    rd = 1;
    step();
    m_vp = 0;
    push_state(req);
  endtask

  task automatic do_commit(int seq, string req);
    cm_v = 1; cm_seq = 16'(seq);
    step();
    while (m_cnt > 0 && !seq_gt(m_seq[m_head], seq)) begin
      m_av[m_head] = 0; m_head = (m_head + 1) % S; m_cnt--;
    end
    push_state(req);
  endtask

  task automatic do_squash(int seq, bit with_other, string req);
    sq_v = 1; sq_seq = 16'(seq);
    if (with_other) begin
      ld_alloc = 1; ld_seq = 16'hFFF0; cm_v = 1; cm_seq = 16'hFFF0;
    end
    step();
    while (m_cnt > 0 && seq_gt(m_seq[(m_tail + S - 1) % S], seq)) begin
      m_tail = (m_tail + S - 1) % S; m_av[m_tail] = 0; m_cnt--;
    end
    push_state(req);
  endtask

  task automatic set_sq_used(int n, string req);
    sq_used = CW'(n); m_sqused = n;
    push_state(req);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int st;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    push_state("R1 reset");

    // R3 allocation order, R2 full refuse
    do_alloc(10, 0, "R3 alloc");
    do_alloc(11, 1, "R3 alloc");
    do_alloc(12, 2, "R3 alloc");
    do_alloc(13, 3, "R2 fill to capacity");
    do_alloc(99, 5, "R2 refused when full");

    // R4 address recording
    do_exec(0, 32'h1234, "R4 exec");
    do_exec(2, 32'h5678, "R4 exec");
    do_check(1, 32'h0000_0010, "R4 unexecuted load no match");
    // R6 block compare and capture
    do_check(0, 32'h12FF, "R6 low bits ignored");
    do_check(0, 32'h5600, "R7 skipped while pending");
    do_read("R7 read clears");
    do_check(1, 32'h1200, "R5 older load outside window");
    do_check(1, 32'h56AA, "R6 match in window");
    do_read("R7 read clears");
    do_exec(3, 32'h56BB, "R4 exec");
    do_check(0, 32'h5601, "R6 first match in order");
    do_read("R7 read clears");

    // R8 commit, R10 free count
    do_commit(11, "R8 commit run");
    set_sq_used(5, "R10 store side limits");
    set_sq_used(7, "R10 store side floored");
    set_sq_used(5, "R10 store side limits");
    do_alloc(14, 4, "R3 tail wraps");
    do_alloc(15, 5, "R3 tail wraps");
    do_squash(13, 1, "R9 squash beats alloc and commit");
    set_sq_used(0, "R10 store side idle");
    do_commit(13, "R8 commit to empty");

    // R11 sequence wrap
    do_alloc(16'hFFFE, 1, "R11 alloc near wrap");
    do_alloc(16'hFFFF, 1, "R11 alloc near wrap");
    do_alloc(16'h0000, 2, "R11 alloc after wrap");
    do_alloc(16'h0001, 2, "R11 alloc after wrap");
    do_commit(16'hFFFF, "R11 commit across wrap");
    do_squash(16'hFFFF, 0, "R11 squash across wrap");

    // R5 window across the last slot
    do_alloc(2, 0, "R3 alloc");
    do_alloc(3, 0, "R3 alloc");
    do_alloc(4, 0, "R3 alloc");
    do_commit(4, "R8 commit all");
    st = int'(lq_tail);
    do_alloc(5, 3, "R3 alloc");
    do_alloc(6, 4, "R3 alloc");
    do_alloc(7, 6, "R3 alloc");
    do_exec((st + 2) % S, 32'hABCD00, "R4 exec");
    do_check(st, 32'hABCD42, "R5 wrapped window hit");
    do_read("R7 read clears");
    do_check(int'(lq_tail), 32'hABCD00, "R5 empty window");
    do_exec(int'(lq_tail), 32'h7700, "R4 free slot write dropped");
    st = int'(lq_tail);
    do_alloc(8, 1, "R3 alloc");
    do_check(st, 32'h7700, "R4 new entry has no address");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule